// File: doc/BRIEF.md
# Keyboard Scan Code Set 1 Decoder

This block sits behind a keyboard byte receiver. It takes one received byte per strobe and turns the byte stream into key events. A byte with no prefix is one key. The 0xE0 prefix marks the next key as extended. The pause key sends a fixed six-byte string that has no break form, and it is reported on a separate pulse.

Each key event carries a 7-bit key code, a flag that tells a release from a press, and the extended flag. All outputs are registered. A result appears on the clock cycle after the byte that completes it. A synchronous reset drops any prefix or partial pause string that is in progress.

Top module: `sc1_decoder`

## Requirements
- R1: A byte other than 0xE0 or 0xE1, with no pending prefix, gives one `ev_valid` pulse on the cycle after it is accepted. At that time `ev_code` = byte[6:0], `ev_release` = byte[7] and `ev_extended` = 0.
- R2: A release byte is the press byte with bit 7 set. For example, 0x01 gives code 0x01 as a press and 0x81 gives code 0x01 as a release. The two bytes report the same code and differ only in `ev_release`.
- R3: The byte 0xE0 produces no event. The next key byte is decoded as in R1 and R2 and reported with `ev_extended` = 1.
- R4: The extended state ends with the event it belongs to. The key byte that follows that event reports `ev_extended` = 0.
- R5: Any number of further 0xE0 bytes received while an extended prefix is pending keep the extended state and produce no event.
- R6: The string E1 1D 45 E1 9D C5 gives exactly one `pause_pulse`, on the cycle after the final C5, and no `ev_valid` for any of its bytes.
- R7: If a byte inside the pause string differs from the expected one, the string is dropped with no event for it. That byte is decoded again as a first byte: it may be a key, 0xE0 or a new 0xE1.
- R8: `ev_valid` and `pause_pulse` are never high together. Neither is raised unless a byte was accepted on the cycle before. `byte_data` is ignored while `byte_valid` is low.
- R9: While `rst` is high, `ev_valid` and `pause_pulse` are held low. Reset also clears a pending extended prefix and a partial pause string.
- R10: A 0xE1 arriving while an extended prefix is pending starts a pause match and cancels the prefix. The key that follows such a pause string is not extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | Strobe: `byte_data` holds a received byte this cycle |
| byte_data | input | 8 | Received keyboard byte |
| ev_valid | output | 1 | One-cycle key event pulse |
| ev_code | output | 7 | Key code of the event |
| ev_release | output | 1 | 1 = key released, 0 = key pressed |
| ev_extended | output | 1 | Event came from a prefixed (extended) key |
| pause_pulse | output | 1 | One-cycle pause key pulse |

## Verification
Every result of this block is due exactly one clock after the strobe of the byte that completes it. This holds for a key event and also for the pause pulse after the final C5. Bytes that only prefix or extend a string must show nothing on that following cycle. The bench drives each byte at a falling edge and samples at the next falling edge, which falls after the single rising edge that registers the result. It then checks either the event fields or the absence of any pulse. A back-to-back case drives bytes on consecutive cycles, to show that each pulse lasts one cycle and belongs to its own byte.

// File: rtl/sc1_pkg.sv
package sc1_pkg;
  localparam int BYTE_W    = 8;
  localparam int CODE_W    = BYTE_W - 1;
  localparam int PAUSE_LEN = 6;
  localparam int IDX_W     = $clog2(PAUSE_LEN);

  localparam logic [BYTE_W-1:0] PFX_EXT   = 8'hE0;
  localparam logic [BYTE_W-1:0] PFX_PAUSE = 8'hE1;

  // expected byte at position idx of the pause string (position 0 is the E1 opener)
  function automatic logic [BYTE_W-1:0] pause_byte(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 8'hE1;
      3'd1:    return 8'h1D;
      3'd2:    return 8'h45;
      3'd3:    return 8'hE1;
      3'd4:    return 8'h9D;
      default: return 8'hC5;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] key_code(input logic [BYTE_W-1:0] b);
    return b[CODE_W-1:0];
  endfunction

  function automatic logic is_release(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  function automatic logic is_prefix(input logic [BYTE_W-1:0] b);
    return (b == PFX_EXT) || (b == PFX_PAUSE);
  endfunction
endpackage

// File: rtl/sc1_pause_match.sv
module sc1_pause_match
  import sc1_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              busy,
  output logic              drop,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PAUSE_LEN - 1);

  logic [IDX_W-1:0] idx_q;
  logic             hit;
  logic             fresh_open;

  assign busy       = (idx_q != '0);
  assign hit        = byte_valid && busy && (byte_data == pause_byte(idx_q));
  assign drop       = byte_valid && busy && !hit;
  assign done       = hit && (idx_q == LAST);
  assign fresh_open = byte_valid && (!busy || drop) && (byte_data == PFX_PAUSE);

  always_ff @(posedge clk) begin
    if (rst)             idx_q <= '0;
    else if (done)       idx_q <= '0;
    else if (hit)        idx_q <= idx_q + 1'b1;
    else if (fresh_open) idx_q <= IDX_W'(1);
    else if (drop)       idx_q <= '0;
  end
endmodule

// File: rtl/sc1_event_reg.sv
module sc1_event_reg
  import sc1_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              key_fire,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic              key_ext,
  input  logic              pause_fire,
  output logic              ev_valid,
  output logic [CODE_W-1:0] ev_code,
  output logic              ev_release,
  output logic              ev_extended,
  output logic              pause_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid    <= 1'b0;
      ev_code     <= '0;
      ev_release  <= 1'b0;
      ev_extended <= 1'b0;
      pause_pulse <= 1'b0;
    end else begin
      ev_valid    <= key_fire;
      pause_pulse <= pause_fire;
      if (key_fire) begin
        ev_code     <= key_code(key_byte);
        ev_release  <= is_release(key_byte);
        ev_extended <= key_ext;
      end
    end
  end
endmodule

// File: rtl/sc1_decoder.sv
module sc1_decoder
  import sc1_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              ev_valid,
  output logic [CODE_W-1:0] ev_code,
  output logic              ev_release,
  output logic              ev_extended,
  output logic              pause_pulse
);
  logic pm_busy, pm_drop, pm_done;
  logic fresh;     // byte decoded as a first byte
  logic key_fire;  // fresh byte that is a key
  logic ext_q;

  sc1_pause_match u_match (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .busy(pm_busy), .drop(pm_drop), .done(pm_done)
  );

  assign fresh    = byte_valid && (!pm_busy || pm_drop);
  assign key_fire = fresh && !is_prefix(byte_data);

  always_ff @(posedge clk) begin
    if (rst)        ext_q <= 1'b0;
    else if (fresh) ext_q <= (byte_data == PFX_EXT);
  end

  sc1_event_reg u_out (
    .clk(clk), .rst(rst), .key_fire(key_fire), .key_byte(byte_data),
    .key_ext(ext_q), .pause_fire(pm_done),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_release(ev_release),
    .ev_extended(ev_extended), .pause_pulse(pause_pulse)
  );
endmodule

// File: rtl/sc1_decoder_chk.sv
module sc1_decoder_chk
  import sc1_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              byte_valid,
  input logic [BYTE_W-1:0] byte_data,
  input logic              ev_valid,
  input logic [CODE_W-1:0] ev_code,
  input logic              ev_release,
  input logic              ev_extended,
  input logic              pause_pulse,
  input logic              pm_busy,
  input logic              pm_drop,
  input logic              ext_q
);
  p_fields_r1: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (ev_code == $past(byte_data[CODE_W-1:0]) && ev_release == $past(byte_data[BYTE_W-1])));

  p_prefix_silent_r3: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> !is_prefix($past(byte_data)));

  p_ext_carried_r3: assert property (@(posedge clk) disable iff (rst)
    (ext_q && byte_valid && !pm_busy && !is_prefix(byte_data)) |=> (ev_valid && ev_extended));

  p_ext_cleared_r4: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !pm_busy && byte_data != PFX_EXT) |=> !ext_q);

  p_pause_no_key_r6: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && pm_busy && !pm_drop) |=> !ev_valid);

  p_pause_last_r6: assert property (@(posedge clk) disable iff (rst)
    pause_pulse |-> ($past(byte_valid) && $past(byte_data) == pause_byte(3'd5)));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid && pause_pulse));

  p_needs_byte_r8: assert property (@(posedge clk) disable iff (rst)
    (ev_valid || pause_pulse) |-> $past(byte_valid));

  p_reset_quiet_r9: assert property (@(posedge clk)
    $past(rst) |-> (!ev_valid && !pause_pulse));
endmodule

bind sc1_decoder sc1_decoder_chk u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
  .ev_valid(ev_valid), .ev_code(ev_code), .ev_release(ev_release),
  .ev_extended(ev_extended), .pause_pulse(pause_pulse),
  .pm_busy(pm_busy), .pm_drop(pm_drop), .ext_q(ext_q)
);

// File: tb/tb_sc1_decoder.sv
module tb_sc1_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       ev_valid, ev_release, ev_extended, pause_pulse;
  logic [6:0] ev_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sc1_decoder dut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_release(ev_release),
    .ev_extended(ev_extended), .pause_pulse(pause_pulse)
  );

  // fields: req[22:19] byte[18:11] ev[10] code[9:3] rel[2] ext[1] pause[0]
  localparam int N = 40;
  localparam logic [22:0] VEC [N] = '{
    {4'd1, 8'h01, 1'b1, 7'h01, 1'b0, 1'b0, 1'b0},  // R1 escape press
    {4'd2, 8'h81, 1'b1, 7'h01, 1'b1, 1'b0, 1'b0},  // R2 escape release
    {4'd1, 8'h02, 1'b1, 7'h02, 1'b0, 1'b0, 1'b0},  // R1
    {4'd2, 8'h82, 1'b1, 7'h02, 1'b1, 1'b0, 1'b0},  // R2
    {4'd3, 8'hE0, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},  // R3 prefix alone
    {4'd3, 8'h48, 1'b1, 7'h48, 1'b0, 1'b1, 1'b0},  // R3 extended press
    {4'd4, 8'h1C, 1'b1, 7'h1C, 1'b0, 1'b0, 1'b0},  // R4 flag gone
    {4'd5, 8'hE0, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},  // R5
    {4'd5, 8'hE0, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},  // R5 repeated prefix
    {4'd5, 8'hC8, 1'b1, 7'h48, 1'b1, 1'b1, 1'b0},  // R5 extended release
    {4'd6, 8'hE1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},  // R6 pause string
    {4'd6, 8'h1D, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd6, 8'h45, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd6, 8'hE1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd6, 8'h9D, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd6, 8'hC5, 1'b0, 7'h00, 1'b0, 1'b0, 1'b1},
    {4'd7, 8'hE1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},  // R7 broken string
    {4'd7, 8'h1D, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'h30, 1'b1, 7'h30, 1'b0, 1'b0, 1'b0},  // R7 mismatch decoded as key
    {4'd7, 8'hE1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'hE0, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},  // R7 mismatch is a prefix
    {4'd7, 8'h4B, 1'b1, 7'h4B, 1'b0, 1'b1, 1'b0},
    {4'd10, 8'hE0, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0}, // R10 prefix then pause
    {4'd10, 8'hE1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd10, 8'h1D, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd10, 8'h45, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd10, 8'hE1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd10, 8'h9D, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd10, 8'hC5, 1'b0, 7'h00, 1'b0, 1'b0, 1'b1},
    {4'd10, 8'h1E, 1'b1, 7'h1E, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'hE1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},  // R7 restart inside string
    {4'd7, 8'h1D, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'h45, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'hE1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'hE1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},  // R7 wrong byte, new opener
    {4'd7, 8'h1D, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'h45, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'hE1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'h9D, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'hC5, 1'b0, 7'h00, 1'b0, 1'b0, 1'b1}
  };

  task automatic expect_out(input int req, input logic ev, input logic [6:0] code,
                            input logic rel, input logic ext, input logic pau);
    checks++;
    if (ev_valid !== ev || pause_pulse !== pau ||
        (ev && (ev_code !== code || ev_release !== rel || ev_extended !== ext))) begin
      fails++;
      $display("FAIL R%0d: got ev=%b code=%h rel=%b ext=%b pause=%b, expected ev=%b code=%h rel=%b ext=%b pause=%b",
               req, ev_valid, ev_code, ev_release, ev_extended, pause_pulse, ev, code, rel, ext, pau);
    end
  endtask

  // one byte strobe, then sample one clock later
  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out(9, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0);  // R9 outputs quiet in reset
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      send(VEC[i][18:11]);
      expect_out(int'(VEC[i][22:19]), VEC[i][10], VEC[i][9:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R8: data moves with strobe low -> nothing
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); byte_data = 8'h01 + 8'(k);
      expect_out(8, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0);
    end

    // R8: back-to-back strobes, each pulse one cycle wide
    @(negedge clk); byte_valid = 1'b1; byte_data = 8'h02;
    @(negedge clk); byte_data = 8'h83;
    expect_out(8, 1'b1, 7'h02, 1'b0, 1'b0, 1'b0);
    @(negedge clk); byte_valid = 1'b0;
    expect_out(8, 1'b1, 7'h03, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    expect_out(8, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0);

    // R9: reset drops a pending extended prefix
    send(8'hE0);
    do_reset();
    send(8'h10);
    expect_out(9, 1'b1, 7'h10, 1'b0, 1'b0, 1'b0);

    // R9: reset drops a partial pause string; 9D then mismatches a fresh match
    send(8'hE1); send(8'h1D); send(8'h45);
    do_reset();
    send(8'hE1);
    expect_out(9, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0);
    send(8'h9D);
    expect_out(9, 1'b1, 7'h1D, 1'b1, 1'b0, 1'b0);
    send(8'hC5);
    expect_out(9, 1'b1, 7'h45, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: bench did not finish, expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule